// File: doc/BRIEF.md
# Masked Packed Integer-to-Float Converter

This unit turns a vector of signed 32-bit integers into single-precision floating-point values in one operation. A single call handles 4, 8 or 16 lanes. Each output lane gets one of three values: the converted number, zero, or the lane's old contents, which arrive on a separate old-destination input. Which one a lane gets depends on the encoding form, a per-lane mask, the zeroing choice and the selected vector length. In the masked form the unit can also broadcast element 0 from a memory-type source to every lane. A full-width register operation can replace the default rounding mode for that one operation.

The unit checks the register-specifier field that each encoding form requires to be all ones. If the field is wrong, it raises an undefined-opcode fault and writes no result. It also reports an inexact flag when any written lane had to be rounded. Operands enter through a valid/ready handshake, and results appear after exactly one register stage. The result, the inexact flag and the fault are presented together with the output valid.

Top module: `vec_i2f_unit`

## Requirements
- R1: Each converted lane is the single-precision value of its signed 32-bit input, rounded to a 24-bit significand. The rounding mode is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. An input of 0 gives +0.0 (all bits 0), and -2^31 converts without overflow to 0xCF000000.
- R2: `vlen_i` selects the active lane count: 00 gives 4, 01 gives 8, 10 or 11 gives 16. In the legacy form (`form_i` = 00) the count is always 4.
- R3: In the legacy form, lanes 4 to 15 (bits 511:128) carry the old destination unchanged.
- R4: In the plain vector form (`form_i` = 01) and the masked form (`form_i` = 10), every lane at or above the active count is zero.
- R5: In the masked form, an active lane whose `mask_i` bit is 1 gets the converted value. An active lane whose mask bit is 0 gets zero when `zero_en_i` is 1, and otherwise its old destination value. In the legacy and plain forms the mask is ignored.
- R6: In the masked form with `bcast_i` = 1 and `src_mem_i` = 1, every active lane converts source element 0 (bits 31:0).
- R7: In the masked form with a register source (`src_mem_i` = 0), `bcast_i` = 1 and 16 active lanes, `rc_i` sets the rounding mode. In every other case `def_rm_i` sets it.
- R8: `inexact_o` is 1 exactly when at least one lane that receives a converted value was rounded. Masked-off and inactive lanes never set it.
- R9: `ud_fault_o` is 1 in three cases: the plain form with `reg_spec_i[3:0]` not equal to 1111, the masked form with `reg_spec_i` not equal to 11111, or `form_i` = 11. A fault presents the old destination unchanged in every lane, with `inexact_o` = 0.
- R10: `in_ready_o` is high when the output register is empty or is being drained. An operation accepted at a clock edge appears on the outputs with `out_valid_o` after that edge, and stays stable while `out_ready_i` is low.
- R11: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation valid |
| in_ready_o | output | 1 | Unit can accept an operation |
| src_i | input | 512 | Source integers, lane n at bits 32n+31:32n |
| old_dst_i | input | 512 | Old destination contents |
| mask_i | input | 16 | Per-lane write mask |
| vlen_i | input | 2 | Vector length select |
| form_i | input | 2 | 00 legacy, 01 plain vector, 10 masked, 11 reserved |
| zero_en_i | input | 1 | Zero masked-off lanes instead of merging |
| bcast_i | input | 1 | Broadcast / rounding-override bit |
| src_mem_i | input | 1 | Source is memory-type (1) or register (0) |
| rc_i | input | 2 | Per-operation rounding mode |
| def_rm_i | input | 2 | Default rounding mode |
| reg_spec_i | input | 5 | Register-specifier field that must be all ones |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 512 | Result vector |
| inexact_o | output | 1 | Some written lane was rounded |
| ud_fault_o | output | 1 | Undefined-opcode fault |

## Verification
The bench builds the unit with its default of 16 lanes. That makes all three vector lengths reachable, including the full-width register case in which the per-operation rounding field takes effect. Directed operations cover the values at the edges of the converter: zero, -2^31, the largest positive input, and halfway cases just above 2^24, each under every rounding mode. Randomized operations then mix all forms, mask and zeroing patterns, broadcast, correct and faulty specifier fields, and output back-pressure.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int ELEM_W = 32;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rm_e;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'b00,
    FORM_PLAIN  = 2'b01,
    FORM_MASKED = 2'b10,
    FORM_RSVD   = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    SEL_OLD  = 2'b00,
    SEL_CVT  = 2'b01,
    SEL_ZERO = 2'b10
  } lane_sel_e;
endpackage

// File: rtl/i2f_lane.sv
module i2f_lane
  import i2f_pkg::*;
(
  input  logic [ELEM_W-1:0] int_i,
  input  rm_e               rm_i,
  output logic [ELEM_W-1:0] flt_o,
  output logic              inexact_o
);
  logic        sign;
  logic [31:0] mag;
  logic [31:0] norm;
  logic [4:0]  lz;
  logic        guard, sticky, lsb, up;
  logic [24:0] sum;
  logic [7:0]  exp_b;

  always_comb begin
    sign = int_i[31];
    // two's complement magnitude; -2^31 maps to 0x8000_0000 unsigned
    mag  = sign ? (~int_i + 32'd1) : int_i;
    lz   = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if (mag[i]) lz = 5'(31 - i);
    end
    norm      = mag << lz;
    lsb       = norm[8];
    guard     = norm[7];
    sticky    = |norm[6:0];
    inexact_o = guard | sticky;
    case (rm_i)
      RM_RNE:  up = guard & (sticky | lsb);
      RM_RDN:  up = sign & inexact_o;
      RM_RUP:  up = ~sign & inexact_o;
      default: up = 1'b0;
    endcase
    sum   = {1'b0, norm[31:8]} + {24'd0, up};
    exp_b = 8'd158 - {3'd0, lz} + {7'd0, sum[24]};
    if (mag == 32'd0) flt_o = '0;
    else              flt_o = {sign, exp_b, sum[24] ? 23'd0 : sum[22:0]};
  end

  always_comb begin
    if (int_i == 32'd0) begin
      AST_ZERO_POS: assert (flt_o == 32'd0 && !inexact_o); // R1
    end
    if (mag < 32'h0100_0000) begin
      AST_SMALL_EXACT: assert (!inexact_o); // R1
    end
  end
endmodule

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import i2f_pkg::*;
#(
  parameter int LANES = 16
) (
  input  form_e            form_i,
  input  logic [1:0]       vlen_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             zero_en_i,
  input  logic             bcast_i,
  input  logic             src_mem_i,
  input  logic [1:0]       rc_i,
  input  logic [1:0]       def_rm_i,
  input  logic [4:0]       reg_spec_i,
  output lane_sel_e        lane_sel_o [LANES],
  output logic             bcast_o,
  output rm_e              rm_o,
  output logic             fault_o
);
  int n_act;

  always_comb begin
    n_act = (vlen_i == 2'b00) ? 4 : (vlen_i == 2'b01) ? 8 : 16;
    if (form_i == FORM_LEGACY) n_act = 4;
    fault_o = (form_i == FORM_RSVD)
            | (form_i == FORM_PLAIN  && reg_spec_i[3:0] != 4'hF)
            | (form_i == FORM_MASKED && reg_spec_i != 5'h1F);
    bcast_o = (form_i == FORM_MASKED) && bcast_i && src_mem_i;
    if (form_i == FORM_MASKED && !src_mem_i && bcast_i && n_act == 16)
      rm_o = rm_e'(rc_i);
    else
      rm_o = rm_e'(def_rm_i);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    always_comb begin
      if (fault_o)
        lane_sel_o[l] = SEL_OLD;
      else if (l >= n_act)
        lane_sel_o[l] = (form_i == FORM_LEGACY) ? SEL_OLD : SEL_ZERO;
      else if (form_i == FORM_MASKED && !mask_i[l])
        lane_sel_o[l] = zero_en_i ? SEL_ZERO : SEL_OLD;
      else
        lane_sel_o[l] = SEL_CVT;
    end

    if (l >= 4) begin : g_upper_chk
      always_comb begin
        if (form_i == FORM_LEGACY) begin
          AST_LEGACY_UPPER: assert (lane_sel_o[l] == SEL_OLD); // R3
        end
        if (fault_o) begin
          AST_FAULT_KEEP: assert (lane_sel_o[l] == SEL_OLD); // R9
        end
      end
    end
  end
endmodule

// File: rtl/vec_i2f_unit.sv
module vec_i2f_unit
  import i2f_pkg::*;
#(
  parameter  int LANES = 16,
  localparam int VEC_W = LANES * ELEM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] old_dst_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [1:0]       vlen_i,
  input  logic [1:0]       form_i,
  input  logic             zero_en_i,
  input  logic             bcast_i,
  input  logic             src_mem_i,
  input  logic [1:0]       rc_i,
  input  logic [1:0]       def_rm_i,
  input  logic [4:0]       reg_spec_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] result_o,
  output logic             inexact_o,
  output logic             ud_fault_o
);
  lane_sel_e        lane_sel [LANES];
  logic             bcast;
  rm_e              rm;
  logic             fault;
  logic [VEC_W-1:0] res_n;
  logic [LANES-1:0] lane_inx;
  logic [LANES-1:0] lane_cvt;

  i2f_ctrl #(.LANES(LANES)) u_ctrl (
    .form_i     (form_e'(form_i)),
    .vlen_i     (vlen_i),
    .mask_i     (mask_i),
    .zero_en_i  (zero_en_i),
    .bcast_i    (bcast_i),
    .src_mem_i  (src_mem_i),
    .rc_i       (rc_i),
    .def_rm_i   (def_rm_i),
    .reg_spec_i (reg_spec_i),
    .lane_sel_o (lane_sel),
    .bcast_o    (bcast),
    .rm_o       (rm),
    .fault_o    (fault)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] op;
    logic [ELEM_W-1:0] flt;
    logic              inx;

    assign op = bcast ? src_i[ELEM_W-1:0] : src_i[l*ELEM_W +: ELEM_W];

    i2f_lane u_lane (
      .int_i     (op),
      .rm_i      (rm),
      .flt_o     (flt),
      .inexact_o (inx)
    );

    assign lane_cvt[l] = (lane_sel[l] == SEL_CVT);
    assign lane_inx[l] = inx;

    always_comb begin
      case (lane_sel[l])
        SEL_CVT:  res_n[l*ELEM_W +: ELEM_W] = flt;
        SEL_ZERO: res_n[l*ELEM_W +: ELEM_W] = '0;
        default:  res_n[l*ELEM_W +: ELEM_W] = old_dst_i[l*ELEM_W +: ELEM_W];
      endcase
    end
  end

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      inexact_o   <= 1'b0;
      ud_fault_o  <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o   <= res_n;
        inexact_o  <= |(lane_cvt & lane_inx);
        ud_fault_o <= fault;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o)
      && $stable(inexact_o) && $stable(ud_fault_o)); // R10
  AST_ACCEPT_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R10
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R10
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ud_fault_o |-> !inexact_o); // R9
endmodule

// File: tb/vec_i2f_unit_test.sv
`timescale 1ns/1ps
module vec_i2f_unit_test;
  typedef struct {
    logic [511:0] src;
    logic [511:0] old;
    logic [15:0]  mask;
    logic [1:0]   vlen, form, rc, drm;
    logic         zero, bc, mem;
    logic [4:0]   spec;
  } stim_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [511:0] src_i = '0;
  logic [511:0] old_dst_i = '0;
  logic [15:0]  mask_i = '0;
  logic [1:0]   vlen_i = '0, form_i = '0, rc_i = '0, def_rm_i = '0;
  logic         zero_en_i = 1'b0, bcast_i = 1'b0, src_mem_i = 1'b0;
  logic [4:0]   reg_spec_i = '1;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [511:0] result_o;
  logic         inexact_o, ud_fault_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    rand_ready = 0;
  bit    finished = 0;
  stim_t pend[$];

  vec_i2f_unit uut (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] ref_cvt(input logic [31:0] v, input int rm, output bit inx);
    longint m, q, r, half;
    bit s, up;
    int p, sh;
    s = v[31];
    m = s ? (64'sd4294967296 - longint'({32'd0, v})) : longint'({32'd0, v});
    inx = 0;
    if (m == 0) return 32'd0;
    p = 0;
    for (int b = 0; b < 32; b++) if (m >= (64'sd1 <<< b)) p = b;
    if (p <= 23) return {s, 8'(127 + p), 23'((m <<< (23 - p)) & 64'h7FFFFF)};
    sh = p - 23;
    q = m >>> sh;
    r = m - (q <<< sh);
    half = 64'sd1 <<< (sh - 1);
    inx = (r != 0);
    case (rm)
      0:       up = (r > half) || (r == half && q[0]);
      1:       up = s && inx;
      2:       up = !s && inx;
      default: up = 0;
    endcase
    q = q + longint'(up);
    if (q == (64'sd1 <<< 24)) begin q = q >>> 1; p = p + 1; end
    return {s, 8'(127 + p), 23'(q & 64'h7FFFFF)};
  endfunction

  function automatic bit is_fault(stim_t s);
    return s.form == 2'b11 || (s.form == 2'b01 && s.spec[3:0] != 4'hF)
        || (s.form == 2'b10 && s.spec != 5'h1F);
  endfunction

  function automatic int act_cnt(stim_t s); // R2
    if (s.form == 2'b00) return 4;
    return s.vlen == 2'b00 ? 4 : s.vlen == 2'b01 ? 8 : 16;
  endfunction

  function automatic string lane_tag(stim_t s, int l);
    if (is_fault(s)) return "R9";
    if (s.form == 2'b00 && l >= 4) return "R3";
    if (l >= act_cnt(s)) return "R2/R4";
    if (s.form == 2'b10 && !s.mask[l]) return "R5";
    if (s.form == 2'b10 && s.bc && s.mem) return "R6";
    if (s.form == 2'b10 && s.bc && !s.mem && act_cnt(s) == 16) return "R7";
    return "R1";
  endfunction

  task automatic compare(stim_t s);
    logic [511:0] exp_r;
    bit exp_i, exp_f, li, bad;
    int rm;
    logic [31:0] e, a;
    string tag;
    exp_f = is_fault(s);
    exp_i = 0;
    rm = (s.form == 2'b10 && !s.mem && s.bc && act_cnt(s) == 16) ? int'(s.rc) : int'(s.drm);
    for (int l = 0; l < 16; l++) begin
      e = s.old[l*32 +: 32];
      if (!exp_f) begin
        if (l >= act_cnt(s)) begin
          if (s.form != 2'b00) e = '0;
        end else if (s.form == 2'b10 && !s.mask[l]) begin
          if (s.zero) e = '0;
        end else begin
          e = ref_cvt((s.form == 2'b10 && s.bc && s.mem) ? s.src[31:0] : s.src[l*32 +: 32], rm, li);
          exp_i |= li;
        end
      end
      exp_r[l*32 +: 32] = e;
    end
    n_vec++;
    bad = 0;
    for (int l = 0; l < 16; l++) begin
      a = result_o[l*32 +: 32];
      e = exp_r[l*32 +: 32];
      if (a !== e && !bad) begin
        tag = lane_tag(s, l);
        $display("FAIL %s lane %0d: got %h expected %h", tag, l, a, e);
        bad = 1;
      end
    end
    if (ud_fault_o !== exp_f) begin
      $display("FAIL R9 fault: got %b expected %b", ud_fault_o, exp_f);
      bad = 1;
    end
    if (inexact_o !== exp_i) begin
      $display("FAIL R8 inexact: got %b expected %b", inexact_o, exp_i);
      bad = 1;
    end
    if (bad) n_bad++;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (out_valid_o && out_ready_i) begin
        if (pend.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R10 output valid: got 1 expected 0 (nothing pending)");
        end else compare(pend.pop_front());
      end
      if (in_valid_i && in_ready_o) begin
        stim_t s;
        s.src = src_i; s.old = old_dst_i; s.mask = mask_i; s.vlen = vlen_i;
        s.form = form_i; s.rc = rc_i; s.drm = def_rm_i; s.zero = zero_en_i;
        s.bc = bcast_i; s.mem = src_mem_i; s.spec = reg_spec_i;
        pend.push_back(s);
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rand_ready) out_ready_i = ($urandom % 4) != 0;
    else out_ready_i = 1'b1;
  end

  task automatic send(stim_t s);
    bit acc;
    src_i = s.src; old_dst_i = s.old; mask_i = s.mask; vlen_i = s.vlen;
    form_i = s.form; rc_i = s.rc; def_rm_i = s.drm; zero_en_i = s.zero;
    bcast_i = s.bc; src_mem_i = s.mem; reg_spec_i = s.spec;
    in_valid_i = 1'b1;
    forever begin
      @(negedge clk_i); acc = in_ready_o;
      @(posedge clk_i); #1;
      if (acc) break;
    end
    in_valid_i = 1'b0;
  endtask

  function automatic stim_t base();
    stim_t s;
    s.src = '0; s.old = '0; s.mask = '1; s.vlen = 2'b10; s.form = 2'b01;
    s.rc = 2'b00; s.drm = 2'b00; s.zero = 0; s.bc = 0; s.mem = 0; s.spec = 5'h1F;
    for (int l = 0; l < 16; l++) s.old[l*32 +: 32] = 32'hA5A5_0000 | 32'(l);
    return s;
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog expired: got hang expected completion");
    finish_run();
  end

  initial begin
    stim_t s;
    repeat (3) @(posedge clk_i);
    #1;
    n_vec++; // R11
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 reset: got valid=%b ready=%b expected valid=0 ready=1", out_valid_o, in_ready_o);
    end
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 edge values under every default rounding mode
    for (int rm = 0; rm < 4; rm++) begin
      s = base(); s.drm = 2'(rm);
      s.src[0*32 +: 32] = 32'd0;         s.src[1*32 +: 32] = 32'h8000_0000;
      s.src[2*32 +: 32] = 32'h7FFF_FFFF; s.src[3*32 +: 32] = 32'd16777217;
      s.src[4*32 +: 32] = 32'd16777219;  s.src[5*32 +: 32] = -32'sd16777217;
      s.src[6*32 +: 32] = 32'd16777216;  s.src[7*32 +: 32] = -32'sd1;
      s.src[8*32 +: 32] = 32'd33554435;  s.src[9*32 +: 32] = -32'sd33554435;
      send(s);
    end
    // R3 legacy keeps upper lanes; R4 zeroes above length
    s = base(); s.form = 2'b00; s.src = {16{32'd77}}; send(s);
    s = base(); s.vlen = 2'b00; s.src = {16{32'd5}}; send(s);
    s = base(); s.vlen = 2'b01; s.src = {16{32'd16777219}}; send(s);
    // R5 merge and zero masking
    s = base(); s.form = 2'b10; s.mask = 16'h5A3C; s.src = {16{32'h0123_4567}}; send(s);
    s.zero = 1; send(s);
    // R8 rounded lanes masked off
    s = base(); s.form = 2'b10; s.mask = 16'h00FF; s.zero = 1;
    s.src = {{8{32'h7FFF_FFFF}}, {8{32'd3}}}; send(s);
    // R6 broadcast from memory
    s = base(); s.form = 2'b10; s.bc = 1; s.mem = 1; s.src = {{15{32'd9}}, 32'd16777219}; send(s);
    // R7 override in full register form; not in 8-lane form
    s = base(); s.form = 2'b10; s.bc = 1; s.mem = 0; s.rc = 2'b10; s.drm = 2'b11;
    s.src = {16{32'd16777217}}; send(s);
    s.vlen = 2'b01; send(s);
    // R9 faults
    s = base(); s.spec = 5'h0F; send(s);
    s.spec = 5'h0E; send(s);
    s.form = 2'b10; s.spec = 5'h0F; send(s);
    s.form = 2'b11; s.spec = 5'h1F; send(s);
    s.form = 2'b00; s.spec = 5'h00; send(s);

    // random mix with back-pressure (R10)
    rand_ready = 1;
    for (int n = 0; n < 2500; n++) begin
      s.form = 2'($urandom); s.vlen = 2'($urandom); s.mask = 16'($urandom);
      s.rc = 2'($urandom); s.drm = 2'($urandom); s.zero = 1'($urandom);
      s.bc = 1'($urandom); s.mem = 1'($urandom);
      s.spec = ($urandom % 8 == 0) ? 5'($urandom) : 5'h1F;
      for (int l = 0; l < 16; l++) begin
        case ($urandom % 4)
          0: s.src[l*32 +: 32] = $urandom;
          1: s.src[l*32 +: 32] = $urandom % 4096;
          2: s.src[l*32 +: 32] = 32'd16777216 + ($urandom % 64);
          default: s.src[l*32 +: 32] = -($urandom % 100000000);
        endcase
        s.old[l*32 +: 32] = $urandom;
      end
      if ($urandom % 5 == 0) begin @(posedge clk_i); #1; end
      send(s);
    end
    rand_ready = 0;
    repeat (6) @(posedge clk_i);
    if (pend.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R10 drain: got %0d pending expected 0", pend.size());
    end
    finish_run();
  end
endmodule